// File: doc/BRIEF.md
# Platform-Window Aware Transaction Scheduler

This block sits between a device's DMA and interrupt sources and its outbound request port. It follows the power window the platform currently offers and decides in which cycle each request may leave. There are three windows. In the idle window the platform is in a low-power state. In the memory-path window reads and writes to memory are allowed. In the processor-active window both bus mastering and interrupts are allowed. Upstream logic decodes the window from a wake wire or from a message. It then presents the window as a 2-bit code with a strobe.

Every request carries a critical flag and a class flag (memory access or interrupt). A critical request goes out on the next cycle in any window. A deferrable request waits in a per-class holding queue until its window opens. The queue then empties in one back-to-back burst, so the platform stays asleep for long stretches instead of waking for each request. If a queue fills to an almost-full level, everything in it is treated as critical and sent out whatever the window, so no request is lost.

Top module: `pwin_sched`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `out_valid` is 0 and `cur_window` reads idle (2'b00). Both queues are empty.
- R2: A request with `req_valid`=1 and `req_crit`=1 appears on the outputs on the next cycle in any window, with the same data and class. It takes precedence over queued traffic in that cycle.
- R3: A deferrable memory request (`req_irq`=0) never leaves while the window is idle, unless its queue is in override. It is released once the window is memory-path (2'b01) or processor-active (2'b10).
- R4: A deferrable interrupt (`req_irq`=1) leaves only in the processor-active window, unless its queue is in override.
- R5: Queued requests leave one per cycle, back-to-back, in arrival order within a class. When both classes may leave, interrupts go first. A pop is skipped in any cycle that carries a critical request.
- R6: The window register loads on `win_strobe` only, and the new value applies from the next cycle. Codes 00, 01 and 10 select idle, memory-path and active. Code 11 is taken as active. Any window may follow any other.
- R7: Once a queue holds at least `AF_LEVEL` entries, it enters override. It then drains in any window until it is empty.
- R8: A deferrable request that arrives at a full queue (`DEPTH` entries, no pop in that cycle) is dropped. Entries already stored stay intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_strobe | input | 1 | Loads `win_code` into the window register |
| win_code | input | 2 | Window code: 00 idle, 01 memory-path, 10 or 11 active |
| req_valid | input | 1 | A request is present this cycle |
| req_crit | input | 1 | 1 = critical, 0 = deferrable |
| req_irq | input | 1 | 1 = interrupt, 0 = memory access |
| req_data | input | DW | Request payload |
| out_valid | output | 1 | A request is issued this cycle |
| out_irq | output | 1 | Class of the issued request |
| out_data | output | DW | Payload of the issued request |
| cur_window | output | 2 | Window in effect (00 idle, 01 memory-path, 10 active) |

## Verification
The case that is hardest to reach is the drop on a full queue. A queue in override pops one entry per cycle while taking at most one push, so on its own it never grows past its threshold. The stimulus gets there in three steps while the window stays idle. It first fills the memory queue to one below its threshold. It then pushes the interrupt queue into override. Because interrupt pops take priority, it can then feed the memory queue one push per cycle while that queue is not drained, so it passes full and starts dropping. A cycle-by-cycle reference model with queues predicts every output. A long random phase adds window strobes, including code 11, on top of mixed traffic.

// File: rtl/pwin_pkg.sv
package pwin_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE = 2'b00,
    WIN_MEM  = 2'b01,
    WIN_ACT  = 2'b10
  } win_e;

  function automatic win_e decode_win(input logic [1:0] code);
    case (code)
      2'b00:   return WIN_IDLE;
      2'b01:   return WIN_MEM;
      default: return WIN_ACT;
    endcase
  endfunction
endpackage

// File: rtl/pwin_window.sv
module pwin_window
  import pwin_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe,
  input  logic [1:0] code,
  output win_e       win
);
  always_ff @(posedge clk) begin
    if (rst)         win <= WIN_IDLE;
    else if (strobe) win <= decode_win(code);
  end

  // R6
  win_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(win));
  // R6
  win_unknown_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && code == 2'b11) |=> win == WIN_ACT);
endmodule

// File: rtl/pwin_defq.sv
module pwin_defq #(
  parameter int DW       = 16,
  parameter int DEPTH    = 16,
  parameter int AF_LEVEL = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic                       rd_en,
  output logic [DW-1:0]              rd_data,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       urgent
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_wr;
  logic [CW-1:0] cnt_n;

  always_comb begin
    do_wr = wr_en && ((count < CW'(DEPTH)) || rd_en);
    cnt_n = count + CW'(do_wr) - CW'(rd_en);
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      rp     <= '0;
      count  <= '0;
      urgent <= 1'b0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (rd_en) rp <= rp + 1'b1;
      count  <= cnt_n;
      urgent <= (cnt_n >= CW'(AF_LEVEL)) || (urgent && cnt_n != '0);
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R5
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> count != '0);
endmodule

// File: rtl/pwin_sched.sv
module pwin_sched
  import pwin_pkg::*;
#(
  parameter int DW       = 16,
  parameter int DEPTH    = 16,
  parameter int AF_LEVEL = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          win_strobe,
  input  logic [1:0]    win_code,
  input  logic          req_valid,
  input  logic          req_crit,
  input  logic          req_irq,
  input  logic [DW-1:0] req_data,
  output logic          out_valid,
  output logic          out_irq,
  output logic [DW-1:0] out_data,
  output logic [1:0]    cur_window
);
  localparam int CW  = $clog2(DEPTH) + 1;
  localparam int MEM = 0;
  localparam int IRQ = 1;

  win_e win;
  pwin_window u_win (.clk(clk), .rst(rst), .strobe(win_strobe), .code(win_code), .win(win));
  assign cur_window = win;

  logic          crit_in;
  logic [1:0]    push, pop, elig, urg;
  logic [DW-1:0] rdat [2];
  logic [CW-1:0] cnt  [2];

  assign crit_in = req_valid && req_crit;

  for (genvar c = 0; c < 2; c++) begin : g_class
    assign push[c] = req_valid && !req_crit && (req_irq == (c == IRQ));
    if (c == IRQ) begin : g_irq
      assign elig[c] = (cnt[c] != '0) && (win == WIN_ACT || urg[c]);
    end else begin : g_mem
      assign elig[c] = (cnt[c] != '0) && (win != WIN_IDLE || urg[c]);
    end
    pwin_defq #(.DW(DW), .DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL)) u_q (
      .clk(clk), .rst(rst), .wr_en(push[c]), .wr_data(req_data),
      .rd_en(pop[c]), .rd_data(rdat[c]), .count(cnt[c]), .urgent(urg[c]));
  end

  always_comb begin
    pop[IRQ] = !crit_in && elig[IRQ];
    pop[MEM] = !crit_in && !elig[IRQ] && elig[MEM];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_irq   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= crit_in || (pop != 2'b00);
      if (crit_in) begin
        out_irq  <= req_irq;
        out_data <= req_data;
      end else if (pop[IRQ]) begin
        out_irq  <= 1'b1;
        out_data <= rdat[IRQ];
      end else if (pop[MEM]) begin
        out_irq  <= 1'b0;
        out_data <= rdat[MEM];
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !out_valid);
  // R2
  crit_pass_chk: assert property (@(posedge clk) disable iff (rst)
    crit_in |=> out_valid && out_data == $past(req_data) && out_irq == $past(req_irq));
  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (win == WIN_IDLE && !urg[MEM]) |-> !pop[MEM]);
  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (win != WIN_ACT && !urg[IRQ]) |-> !pop[IRQ]);
  // R7
  override_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (urg[MEM] && cnt[MEM] != '0 && !crit_in) |=> out_valid);
endmodule

// File: tb/tb_pwin_sched.sv
`timescale 1ns/1ps
module tb_pwin_sched;
  localparam int DW = 16, DEPTH = 16, AF = 12;

  logic clk = 0, rst = 1;
  logic win_strobe = 0, req_valid = 0, req_crit = 0, req_irq = 0;
  logic [1:0] win_code = 0;
  logic [DW-1:0] req_data = 0;
  logic out_valid, out_irq;
  logic [DW-1:0] out_data;
  logic [1:0] cur_window;

  pwin_sched #(.DW(DW), .DEPTH(DEPTH), .AF_LEVEL(AF)) dut (
    .clk(clk), .rst(rst), .win_strobe(win_strobe), .win_code(win_code),
    .req_valid(req_valid), .req_crit(req_crit), .req_irq(req_irq), .req_data(req_data),
    .out_valid(out_valid), .out_irq(out_irq), .out_data(out_data), .cur_window(cur_window));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [DW-1:0] mq[$], iq[$];
  bit murg, iurg, ev, ei;
  logic [DW-1:0] ed;
  logic [1:0] ewin;
  string ereq = "R1";
  logic [DW-1:0] seq = 16'h100;

  // reference model: window, two queues, override flags
  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); iq.delete(); murg = 0; iurg = 0;
      ev = 0; ei = 0; ed = 0; ewin = 2'b00; ereq = "R1";
    end else begin
      bit crit, ie, me;
      crit = req_valid && req_crit;
      ie = iq.size() > 0 && (ewin == 2'b10 || iurg);
      me = mq.size() > 0 && (ewin != 2'b00 || murg);
      ev = 0;
      if (crit) begin
        ev = 1; ei = req_irq; ed = req_data; ereq = "R2";
      end else if (ie) begin
        ev = 1; ei = 1; ed = iq.pop_front(); ereq = iurg ? "R7" : "R4";
      end else if (me) begin
        ev = 1; ei = 0; ed = mq.pop_front(); ereq = murg ? "R7" : "R3";
      end else ereq = "R5";
      if (req_valid && !req_crit) begin
        if (req_irq) begin if (iq.size() < DEPTH) iq.push_back(req_data); end
        else begin if (mq.size() < DEPTH) mq.push_back(req_data); end
      end
      murg = (mq.size() >= AF) || (murg && mq.size() != 0);
      iurg = (iq.size() >= AF) || (iurg && iq.size() != 0);
      if (win_strobe) ewin = (win_code == 2'b11) ? 2'b10 : win_code;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (out_valid !== ev || (ev && (out_data !== ed || out_irq !== ei))) begin
      errors++;
      $display("FAIL %s: valid/irq/data actual %b/%b/%h expected %b/%b/%h",
               ereq, out_valid, out_irq, out_data, ev, ei, ed);
    end
    checks++;
    if (cur_window !== ewin) begin
      errors++;
      $display("FAIL R6: window actual %b expected %b", cur_window, ewin);
    end
  end

  task automatic step(input bit v, input bit c, input bit irq, input bit stb = 0,
                      input logic [1:0] code = 2'b00);
    @(negedge clk);
    req_valid = v; req_crit = c; req_irq = irq;
    req_data = seq; seq++;
    win_strobe = stb; win_code = code;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;                              // R1 checked on following cycles
    idle_cycles(2);
    // R3 R4: deferrables held in idle; R2 critical passes through
    step(1, 0, 0); step(1, 0, 1); step(1, 1, 0); step(1, 0, 0); step(1, 0, 1);
    step(1, 1, 1); step(1, 0, 0);
    idle_cycles(3);
    // R6: memory-path window releases memory burst only (R5 back-to-back)
    step(0, 0, 0, 1, 2'b01);
    idle_cycles(5);
    // R6: code 11 means active, releases interrupts
    step(0, 0, 0, 1, 2'b11);
    idle_cycles(4);
    // R5: mixed arrivals in active window, critical preempts a pop
    step(0, 0, 0, 1, 2'b00);
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 1); step(1, 0, 1);
    step(0, 0, 0, 1, 2'b10);
    step(1, 1, 0); step(1, 1, 1);
    idle_cycles(6);
    // R7: fill memory queue to threshold while idle
    step(0, 0, 0, 1, 2'b00);
    for (int i = 0; i < AF; i++) step(1, 0, 0);
    idle_cycles(AF + 3);
    // R8: memory queue to AF-1, interrupt queue to override, then overfill memory
    for (int i = 0; i < AF - 1; i++) step(1, 0, 0);
    for (int i = 0; i < AF; i++) step(1, 0, 1);
    for (int i = 0; i < 8; i++) step(1, 0, 0);
    idle_cycles(2 * DEPTH + 4);
    // random phase covering all window transitions
    for (int i = 0; i < 3000; i++) begin
      bit stb;
      stb = ($urandom % 16) == 0;
      step($urandom % 3 != 0, $urandom % 5 == 0, $urandom % 2, stb, 2'($urandom));
    end
    step(0, 0, 0, 1, 2'b10);
    idle_cycles(2 * DEPTH + 4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule